// File: doc/BRIEF.md
# Staged Inrush Charge Sequencer

This block controls how a series supercapacitor bank is charged from a live DC bus without making the bus sag. Charging of an empty bank starts through a small pre-charge switch. The sequencer watches a sampled bank voltage. When that voltage reaches a programmable hand-over level, it opens the pre-charge switch, waits one cycle with both switches open, and then closes the main switch. In the main stage it produces a target voltage. In ramp mode the target rises at a programmed slope. In step mode it jumps straight to the full value.

For each stage the block outputs a current-limit code. The code is derated by a temperature code: full strength when cool, half strength when warm, and zero when hot. When it is hot, charging pauses. A loss of the bus-good flag also pauses charging, because the bus is the priority supply. Charging resumes from the pre-charge stage once conditions clear.

When charging completes, both switches open. If a hold-up discharge later drops the bank below a recharge level, the whole staged sequence runs again. The main path is never connected directly. A pre-charge stage that does not reach hand-over in time produces a latched fault. Only dropping the enable clears that fault.

Top module: `scap_inrush_seq`

## Requirements
- R1: While reset is asserted and immediately after it: status reads 0 (idle), both gate enables are low, the current-limit code is 0 and the target voltage is 0.
- R2: In idle with `en` high, `abort` low, `bus_ok` high and temperature not hot, the next cycle enters pre-charge (status 1) with only `pre_gate` high.
- R3: In pre-charge, a bank voltage at or above `vhand` moves the sequencer to the gap state (status 2, both gates low) for exactly one cycle, then to main charge (status 3, only `main_gate` high). The two gate enables are never high together.
- R4: If pre-charge lasts `pre_timeout` cycles without reaching `vhand`, status becomes 6 (fault) and both gates go low. The fault ignores `abort` and every other input, and is cleared only by `en` low, which returns the block to idle.
- R5: In main charge, a bank voltage at or above `vtarget` enters done (status 4) with both gates low.
- R6: In done, a bank voltage strictly below `vrecharge` (with bus good and not hot) re-enters pre-charge, never main charge directly. `main_gate` only rises two cycles after `pre_gate` was high.
- R7: `ilim_code` is `ilim_pre` in pre-charge, `ilim_main` in main charge, and 0 in every other state. The value is passed at full strength when `temp <= temp_t1`, halved (shift right by one) when `temp_t1 < temp <= temp_t2`, and forced to 0 when `temp > temp_t2`.
- R8: A temperature above `temp_t2` in pre-charge, gap or main charge enters wait (status 5) on the next cycle with both gates low. Wait returns to pre-charge once the temperature is no longer hot and the bus is good.
- R9: `bus_ok` low in pre-charge, gap or main charge enters wait on the next cycle with both gates low. Recovery goes through pre-charge.
- R10: `en` low, or `abort` high (outside fault), returns the sequencer to idle on the next cycle.
- R11: In ramp mode, the first main-charge cycle shows a target of min(bank voltage sampled at the gap-to-main edge, `vtarget`). Each further main-charge cycle adds `ramp_step`, saturating at `vtarget`. The target is 0 outside main charge.
- R12: In step mode, the target equals `vtarget` on every main-charge cycle and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable; low returns to idle and clears a fault |
| abort | input | 1 | Forces idle outside the fault state |
| bus_ok | input | 1 | Supply bus is healthy |
| vbank | input | VW | Sampled bank voltage code |
| temp | input | TW | Temperature code |
| vtarget | input | VW | Full-charge voltage code |
| vhand | input | VW | Pre-charge to main hand-over level |
| vrecharge | input | VW | Level below which a charged bank is recharged |
| temp_t1 | input | TW | Upper bound of the full-current band |
| temp_t2 | input | TW | Upper bound of the half-current band |
| ilim_pre | input | LW | Current-limit code for pre-charge |
| ilim_main | input | LW | Current-limit code for main charge |
| pre_timeout | input | CW | Maximum pre-charge length in cycles (at least 1) |
| ramp_step | input | VW | Target increment per cycle in ramp mode |
| pre_gate | output | 1 | Pre-charge switch enable |
| main_gate | output | 1 | Main switch enable |
| ilim_code | output | LW | Derated current-limit code |
| vref | output | VW | Target voltage for the charge loop |
| status | output | 3 | 0 idle, 1 pre-charge, 2 gap, 3 main, 4 done, 5 wait, 6 fault |

## Verification
The embedded properties check four things on every cycle: the two gate enables are mutually exclusive, the main gate rises only after a one-cycle gap that follows pre-charge, a hot reading or bus loss opens both gates on the next cycle, and the ramp target never falls during main charge. Other behaviour depends on a specific history of inputs, so only the bench scenarios can show it. That covers the exact pre-charge timeout length, the sticky fault, the strict comparison at the recharge level, the boundaries of the temperature bands, and the ramp starting point and saturation. The bench also runs a step-mode instance beside the ramp-mode one to show the two target variants.

// File: rtl/scap_seq_pkg.sv
package scap_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_GAP   = 3'd2,
      ST_MAIN  = 3'd3,
      ST_DONE  = 3'd4,
      ST_WAIT  = 3'd5,
      ST_FAULT = 3'd6
   } seq_state_t;
endpackage

// File: rtl/scap_temp_derate.sv
module scap_temp_derate #(
   parameter int TW = 8,
   parameter int LW = 6
) (
   input  logic [TW-1:0] temp,
   input  logic [TW-1:0] temp_t1,
   input  logic [TW-1:0] temp_t2,
   input  logic [LW-1:0] code_in,
   output logic [LW-1:0] code_out,
   output logic          hot
);
   logic warm;

   always_comb begin
      hot  = (temp > temp_t2);
      warm = (temp > temp_t1) && !hot;
      if (hot)
         code_out = '0;
      else if (warm)
         code_out = code_in >> 1;
      else
         code_out = code_in;
   end
endmodule

// File: rtl/scap_pre_timer.sv
module scap_pre_timer #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] limit,
   output logic          expired
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last    = limit - 1'b1;
   assign expired = run && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (run)
         cnt <= cnt + 1'b1;
      else
         cnt <= '0;
   end
endmodule

// File: rtl/scap_vref_ramp.sv
module scap_vref_ramp #(
   parameter int VW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          load,
   input  logic [VW-1:0] start_v,
   input  logic [VW-1:0] vtarget,
   input  logic [VW-1:0] step,
   output logic [VW-1:0] vref
);
   localparam int SW = VW + 1;

   logic [SW-1:0] sum;
   logic [VW-1:0] adv;
   logic [VW-1:0] start_sat;

   always_comb begin
      sum       = {1'b0, vref} + {1'b0, step};
      adv       = (sum > {1'b0, vtarget}) ? vtarget : sum[VW-1:0];
      start_sat = (start_v > vtarget) ? vtarget : start_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vref <= '0;
      else if (!run)
         vref <= '0;
      else if (load)
         vref <= start_sat;
      else
         vref <= adv;
   end

   assert_ramp_mono_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load) |=> (vref >= $past(vref)));
endmodule

// File: rtl/scap_inrush_seq.sv
module scap_inrush_seq
   import scap_seq_pkg::*;
#(
   parameter int VW      = 10,
   parameter int TW      = 8,
   parameter int LW      = 6,
   parameter int CW      = 16,
   parameter bit RAMP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          abort,
   input  logic          bus_ok,
   input  logic [VW-1:0] vbank,
   input  logic [TW-1:0] temp,
   input  logic [VW-1:0] vtarget,
   input  logic [VW-1:0] vhand,
   input  logic [VW-1:0] vrecharge,
   input  logic [TW-1:0] temp_t1,
   input  logic [TW-1:0] temp_t2,
   input  logic [LW-1:0] ilim_pre,
   input  logic [LW-1:0] ilim_main,
   input  logic [CW-1:0] pre_timeout,
   input  logic [VW-1:0] ramp_step,
   output logic          pre_gate,
   output logic          main_gate,
   output logic [LW-1:0] ilim_code,
   output logic [VW-1:0] vref,
   output logic [2:0]    status
);
   if (VW < 4 || VW > 16) begin : g_bad_vw
      $error("VW out of range");
   end
   if (TW < 2) begin : g_bad_tw
      $error("TW too small");
   end
   if (LW < 2) begin : g_bad_lw
      $error("LW too small");
   end
   if (CW < 2) begin : g_bad_cw
      $error("CW too small");
   end

   seq_state_t    state, nstate;
   logic          hot, supply_ok, pre_expired;
   logic [LW-1:0] stage_code;
   logic [VW-1:0] eff_start, eff_step;

   scap_temp_derate #(.TW(TW), .LW(LW)) u_derate (
      .temp(temp), .temp_t1(temp_t1), .temp_t2(temp_t2),
      .code_in(stage_code), .code_out(ilim_code), .hot(hot)
   );

   scap_pre_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state == ST_PRE),
      .limit(pre_timeout), .expired(pre_expired)
   );

   if (RAMP_EN) begin : g_ramp
      assign eff_start = vbank;
      assign eff_step  = ramp_step;
   end else begin : g_step
      assign eff_start = vtarget;
      assign eff_step  = '0;
   end

   scap_vref_ramp #(.VW(VW)) u_ramp (
      .clk(clk), .rst_n(rst_n),
      .run(nstate == ST_MAIN),
      .load((state == ST_GAP) && (nstate == ST_MAIN)),
      .start_v(eff_start), .vtarget(vtarget), .step(eff_step),
      .vref(vref)
   );

   assign supply_ok = bus_ok && !hot;

   always_comb begin
      nstate = state;
      if (!en)
         nstate = ST_IDLE;
      else if (state == ST_FAULT)
         nstate = ST_FAULT;
      else if (abort)
         nstate = ST_IDLE;
      else begin
         case (state)
            ST_IDLE, ST_WAIT:
               if (supply_ok) nstate = ST_PRE;
            ST_PRE:
               if (!supply_ok)          nstate = ST_WAIT;
               else if (vbank >= vhand) nstate = ST_GAP;
               else if (pre_expired)    nstate = ST_FAULT;
            ST_GAP:
               if (!supply_ok) nstate = ST_WAIT;
               else            nstate = ST_MAIN;
            ST_MAIN:
               if (!supply_ok)            nstate = ST_WAIT;
               else if (vbank >= vtarget) nstate = ST_DONE;
            ST_DONE:
               if (supply_ok && (vbank < vrecharge)) nstate = ST_PRE;
            default:
               nstate = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= nstate;
   end

   always_comb begin
      pre_gate   = (state == ST_PRE);
      main_gate  = (state == ST_MAIN);
      status     = state;
      stage_code = (state == ST_PRE)  ? ilim_pre  :
                   (state == ST_MAIN) ? ilim_main : '0;
   end

   assert_gate_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(pre_gate && main_gate));
   assert_gap_before_main_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_gate) |-> !$past(pre_gate));
   assert_main_via_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_gate) |-> $past(pre_gate, 2));
   assert_hot_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hot |=> (!pre_gate && !main_gate));
   assert_bus_loss_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ok |=> (!pre_gate && !main_gate));
endmodule

// File: tb/scap_inrush_seq_test.sv
module scap_inrush_seq_test;
   localparam int VW = 10, TW = 8, LW = 6, CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0, abort = 1'b0, bus_ok = 1'b0;
   logic [VW-1:0] vbank = '0;
   logic [TW-1:0] temp = 8'd25;
   logic [VW-1:0] vtarget = 10'd800, vhand = 10'd240, vrecharge = 10'd700;
   logic [TW-1:0] temp_t1 = 8'd100, temp_t2 = 8'd150;
   logic [LW-1:0] ilim_pre = 6'd8, ilim_main = 6'd40;
   logic [CW-1:0] pre_timeout = 16'd20;
   logic [VW-1:0] ramp_step = 10'd50;

   logic          pre_gate, main_gate, s_pre, s_main;
   logic [LW-1:0] ilim_code, s_ilim;
   logic [VW-1:0] vref, s_vref;
   logic [2:0]    status, s_status;

   int    checks = 0, failures = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";

   int ms = 0, mc = 0, mv = 0, mvs = 0;

   always #4 clk = ~clk;

   scap_inrush_seq #(.VW(VW), .TW(TW), .LW(LW), .CW(CW), .RAMP_EN(1'b1)) uut (
      .clk, .rst_n, .en, .abort, .bus_ok, .vbank, .temp, .vtarget, .vhand,
      .vrecharge, .temp_t1, .temp_t2, .ilim_pre, .ilim_main, .pre_timeout,
      .ramp_step, .pre_gate, .main_gate, .ilim_code, .vref, .status
   );

   scap_inrush_seq #(.VW(VW), .TW(TW), .LW(LW), .CW(CW), .RAMP_EN(1'b0)) uut_step (
      .clk, .rst_n, .en, .abort, .bus_ok, .vbank, .temp, .vtarget, .vhand,
      .vrecharge, .temp_t1, .temp_t2, .ilim_pre, .ilim_main, .pre_timeout,
      .ramp_step, .pre_gate(s_pre), .main_gate(s_main), .ilim_code(s_ilim),
      .vref(s_vref), .status(s_status)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      int ns;
      bit ok;
      if (!rst_n) begin
         ms = 0; mc = 0; mv = 0; mvs = 0;
      end else begin
         ok = bus_ok && !(int'(temp) > int'(temp_t2));
         ns = ms;
         if (!en) ns = 0;
         else if (ms == 6) ns = 6;
         else if (abort) ns = 0;
         else if (ms == 0 || ms == 5) begin if (ok) ns = 1; end
         else if (ms == 1) begin
            if (!ok) ns = 5;
            else if (int'(vbank) >= int'(vhand)) ns = 2;
            else if (mc == int'(pre_timeout) - 1) ns = 6;
         end
         else if (ms == 2) ns = ok ? 3 : 5;
         else if (ms == 3) begin
            if (!ok) ns = 5;
            else if (int'(vbank) >= int'(vtarget)) ns = 4;
         end
         else if (ms == 4) begin
            if (ok && int'(vbank) < int'(vrecharge)) ns = 1;
         end
         if (ns == 3) begin
            if (ms == 2) mv = min2(int'(vbank), int'(vtarget));
            else         mv = min2(mv + int'(ramp_step), int'(vtarget));
            mvs = int'(vtarget);
         end else begin
            mv = 0; mvs = 0;
         end
         mc = (ms == 1) ? mc + 1 : 0;
         ms = ns;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      int sel, exp_ilim;
      if (!finished) begin
         sel = (ms == 1) ? int'(ilim_pre) : (ms == 3) ? int'(ilim_main) : 0;
         if (int'(temp) > int'(temp_t2))      exp_ilim = 0;
         else if (int'(temp) > int'(temp_t1)) exp_ilim = sel / 2;
         else                                 exp_ilim = sel;
         chk({cur_req, " status"}, int'(status), ms);
         chk({cur_req, " pre_gate"}, int'(pre_gate), int'(ms == 1));
         chk({cur_req, " main_gate"}, int'(main_gate), int'(ms == 3));
         chk({cur_req, " ilim_code"}, int'(ilim_code), exp_ilim);
         chk({cur_req, " vref ramp"}, int'(vref), mv);
         chk({cur_req, " R12 vref step"}, int'(s_vref), mvs);
      end
   end

   task automatic cyc(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      // R1 reset state
      cur_req = "R1";
      cyc(3);
      chk("R1 status", int'(status), 0);
      chk("R1 gates", int'(pre_gate) + int'(main_gate), 0);
      chk("R1 ilim", int'(ilim_code), 0);
      chk("R1 vref", int'(vref), 0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 idle after reset", int'(status), 0);

      // R2 start
      cur_req = "R2";
      en = 1'b1; bus_ok = 1'b1; temp = 8'd25; vbank = 10'd0;
      cyc();
      chk("R2 pre-charge entered", int'(status), 1);
      chk("R2 pre_gate", int'(pre_gate), 1);
      chk("R7 pre code full", int'(ilim_code), 8);

      // R3 hand-over, R11 ramp
      cur_req = "R3";
      vbank = 10'd239; cyc(3);
      chk("R3 below hand-over", int'(status), 1);
      vbank = 10'd240; cyc();
      chk("R3 gap state", int'(status), 2);
      chk("R3 gap gates open", int'(pre_gate) + int'(main_gate), 0);
      cyc();
      chk("R3 main state", int'(status), 3);
      chk("R3 main_gate", int'(main_gate), 1);
      chk("R11 ramp start", int'(vref), 240);
      chk("R12 step start", int'(s_vref), 800);
      cur_req = "R11";
      vbank = 10'd300; cyc();
      chk("R11 ramp step", int'(vref), 290);
      cyc(20);
      chk("R11 ramp saturates", int'(vref), 800);

      // R5 completion
      cur_req = "R5";
      vbank = 10'd800; cyc();
      chk("R5 done", int'(status), 4);
      chk("R5 gates open", int'(pre_gate) + int'(main_gate), 0);

      // R6 recharge
      cur_req = "R6";
      vbank = 10'd700; cyc(2);
      chk("R6 at recharge level stays done", int'(status), 4);
      vbank = 10'd699; cyc();
      chk("R6 recharge via pre", int'(pre_gate), 1);
      chk("R6 main stays open", int'(main_gate), 0);
      cyc(2);
      chk("R6 main after staging", int'(status), 3);

      // R7 derating bands, R8 hot pause
      cur_req = "R7";
      temp = 8'd100; cyc();
      chk("R7 at t1 full", int'(ilim_code), 40);
      temp = 8'd101; cyc();
      chk("R7 above t1 half", int'(ilim_code), 20);
      temp = 8'd150; cyc();
      chk("R7 at t2 half", int'(ilim_code), 20);
      cur_req = "R8";
      temp = 8'd151; cyc();
      chk("R8 hot wait", int'(status), 5);
      chk("R8 hot gates", int'(pre_gate) + int'(main_gate), 0);
      chk("R7 hot code", int'(ilim_code), 0);
      cyc(3);
      temp = 8'd50; cyc();
      chk("R8 resume pre", int'(status), 1);

      // R9 bus loss
      cur_req = "R9";
      cyc(2);
      chk("R9 back in main", int'(status), 3);
      bus_ok = 1'b0; cyc();
      chk("R9 bus loss wait", int'(status), 5);
      cyc(2);
      chk("R9 still waiting", int'(pre_gate) + int'(main_gate), 0);
      bus_ok = 1'b1; cyc();
      chk("R9 resume pre", int'(status), 1);

      // R10 abort
      cur_req = "R10";
      abort = 1'b1; cyc();
      chk("R10 abort idle", int'(status), 0);
      cyc();
      chk("R10 held idle", int'(status), 0);
      abort = 1'b0; cyc();
      chk("R10 restart", int'(status), 1);

      // R4 timeout and sticky fault
      cur_req = "R4";
      abort = 1'b1; cyc();
      abort = 1'b0; vbank = 10'd0; cyc();
      chk("R4 pre entered", int'(status), 1);
      cyc(19);
      chk("R4 last pre cycle", int'(status), 1);
      cyc();
      chk("R4 fault", int'(status), 6);
      chk("R4 fault gates", int'(pre_gate) + int'(main_gate), 0);
      abort = 1'b1; cyc();
      chk("R4 abort ignored", int'(status), 6);
      abort = 1'b0; vbank = 10'd300; cyc(3);
      chk("R4 fault sticky", int'(status), 6);
      en = 1'b0; cyc();
      chk("R4 en low clears", int'(status), 0);
      en = 1'b1; cyc();
      chk("R10 enable restarts", int'(status), 1);

      // mixed patterns against the model
      cur_req = "R3";
      for (int i = 0; i < 400; i++) begin
         vbank  = 10'((i * 37) % 900);
         temp   = 8'((i % 23 == 0) ? 160 : (i % 11 == 0) ? 120 : 40);
         bus_ok = (i % 29) != 7;
         cyc();
      end

      finish_run();
   end
endmodule